// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block keeps wall-clock time as a plain count of seconds. A slow oscillator, presented to the block as a one-cycle enable on the system clock (`oscTick`), is divided down to a once-per-second tick by a prescaler. The divisor is programmable, and a trim amount stretches one tick period out of every 1024 so that the long-term rate can be fine-tuned. Each tick advances a 32-bit seconds counter and sets a tick flag. When the counter reaches the value held in an alarm register, an alarm flag is raised.

Software reaches four registers through a simple port. A write takes effect at the clock edge on which `regWr` is high, and read data is driven combinationally from `regAddr` in the same cycle. The status register holds two enables next to two event flags, and a flag is cleared by writing a one to it. Each event drives its own interrupt line: the line is high while its flag and its enable are both set.

Top module: `secs_rtc`

## Requirements
- R1: After reset every register reads zero and both `tickIrq` and `alarmIrq` are low.
- R2: The alarm register is at offset 0x00, the seconds counter at 0x04, the trim/divider register at 0x08 and the status register at 0x10. Any other offset reads zero, and a write to it changes nothing.
- R3: In the status register, bit 3 enables the tick interrupt, bit 2 enables the alarm interrupt, bit 1 is the tick flag and bit 0 is the alarm flag. Writing 1 to a flag bit clears that flag and writing 0 leaves it as it is. A write cannot set a flag. The enable bits are plain read/write bits, and bits 31:4 read zero.
- R4: The 32-bit seconds counter advances by one on each tick and wraps from 0xFFFFFFFF to 0. A write loads the written value. When a write and a tick fall in the same cycle, the written value is kept.
- R5: Each tick sets the tick flag. If a tick and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R6: The alarm flag is set one cycle after the counter and the alarm register become equal, whether that comes from a tick or from a register write. It is not set again while they stay equal.
- R7: The prescaler counts only cycles in which `oscTick` is high. It emits one tick on every (divider + 1)-th such cycle.
- R8: The trim/divider register holds the divider in bits 15:0 and the trim in bits 25:16, and bits 31:26 read zero. A write to it restarts the prescaler count and the 1024-tick trim sequence.
- R9: While the divider field is zero, the prescaler behaves as if the divider were 32767, giving 32768 enables per tick.
- R10: Counting from the last trim/divider write, every 1024th tick period is longer by the trim value, measured in enables.
- R11: `tickIrq` is high exactly when the tick flag and bit 3 are both set. `alarmIrq` is high exactly when the alarm flag and bit 2 are both set. The two lines are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oscTick | input | 1 | One-cycle enable per slow oscillator period |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| tickIrq | output | 1 | Tick interrupt line |
| alarmIrq | output | 1 | Alarm interrupt line |

## Verification
Two pairs of events can fall on the same edge. A prescaler tick can coincide with a software write-one-to-clear of the tick flag, and a tick can coincide with a write that loads the seconds counter. The bench reloads the prescaler with a divider of 3, feeds exactly three enables, then raises the write strobe together with the fourth enable. In the first case it judges the result by reading back a still-set tick flag. In the second it reads back the written count rather than that value plus one.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TRIM   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;

  // Status register bit positions
  localparam int ST_TICK_EN    = 3;
  localparam int ST_ALARM_EN   = 2;
  localparam int ST_TICK_FLAG  = 1;
  localparam int ST_ALARM_FLAG = 0;

  // Bit position of the trim field in the trim/divider register
  localparam int TRIM_LSB = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrAlarm;
    logic wrCount;
    logic wrTrim;
    logic wrStatus;
    logic tick;
  } rtcStrobes_t;

endpackage

// File: rtl/secs_rtc_prescaler.sv
module secs_rtc_prescaler #(
  parameter int DIV_W          = 16,
  parameter int TRIM_W         = 10,
  parameter int TRIM_SPAN_LOG2 = 10,
  parameter int DEFAULT_DIV    = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oscTick,
  input  logic              reload,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [TRIM_W-1:0] trimVal,
  output logic              tickOut
);

  localparam int PER_W = ((DIV_W > TRIM_W) ? DIV_W : TRIM_W) + 1;

  logic [PER_W-1:0]          preCnt;
  logic [PER_W-1:0]          period;
  logic [DIV_W-1:0]          baseDiv;
  logic [TRIM_SPAN_LOG2-1:0] tickNum;
  logic                      lastSlot;
  logic                      periodDone;

  // A zero divider falls back to the default divisor
  assign baseDiv    = (divVal == '0) ? DIV_W'(DEFAULT_DIV) : divVal;
  // The final period of each trim span is stretched
  assign lastSlot   = &tickNum;
  assign period     = PER_W'(baseDiv) + (lastSlot ? PER_W'(trimVal) : '0);
  assign periodDone = (preCnt >= period);
  assign tickOut    = oscTick && periodDone && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      tickNum <= '0;
    end else if (reload) begin
      preCnt  <= '0;
      tickNum <= '0;
    end else if (oscTick) begin
      if (periodDone) begin
        preCnt  <= '0;
        tickNum <= tickNum + 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/secs_rtc_ctrl.sv
module secs_rtc_ctrl
  import secs_rtc_pkg::*;
#(
  parameter int DIV_W          = 16,
  parameter int TRIM_W         = 10,
  parameter int TRIM_SPAN_LOG2 = 10,
  parameter int DEFAULT_DIV    = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oscTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [TRIM_W-1:0] trimVal,
  output rtcStrobes_t       strb
);

  logic wrTrimStb;
  logic tickStb;

  assign wrTrimStb = regWr && (regAddr == OFS_TRIM);

  secs_rtc_prescaler #(
    .DIV_W         (DIV_W),
    .TRIM_W        (TRIM_W),
    .TRIM_SPAN_LOG2(TRIM_SPAN_LOG2),
    .DEFAULT_DIV   (DEFAULT_DIV)
  ) prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .oscTick(oscTick),
    .reload (wrTrimStb),
    .divVal (divVal),
    .trimVal(trimVal),
    .tickOut(tickStb)
  );

  always_comb begin
    strb.wrAlarm  = regWr && (regAddr == OFS_ALARM);
    strb.wrCount  = regWr && (regAddr == OFS_COUNT);
    strb.wrTrim   = wrTrimStb;
    strb.wrStatus = regWr && (regAddr == OFS_STATUS);
    strb.tick     = tickStb;
  end

endmodule

// File: rtl/secs_rtc_dp.sv
module secs_rtc_dp
  import secs_rtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16,
  parameter int TRIM_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rtcStrobes_t       strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [CNT_W-1:0]  alarmQ,
  output logic [CNT_W-1:0]  countQ,
  output logic [DIV_W-1:0]  divQ,
  output logic [TRIM_W-1:0] trimQ,
  output logic [3:0]        statusQ,
  output logic              tickIrq,
  output logic              alarmIrq
);

  logic tickEn, alarmEn, tickFlag, alarmFlag;
  logic matchNow, matchQ, matchRise;
  logic clrTick, clrAlarm;

  assign matchNow  = (countQ == alarmQ);
  assign matchRise = matchNow && !matchQ;
  assign clrTick   = strb.wrStatus && regWdata[ST_TICK_FLAG];
  assign clrAlarm  = strb.wrStatus && regWdata[ST_ALARM_FLAG];

  // Alarm, counter and trim/divider storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarmQ <= '0;
      countQ <= '0;
      divQ   <= '0;
      trimQ  <= '0;
    end else begin
      if (strb.wrAlarm) alarmQ <= regWdata[CNT_W-1:0];
      if (strb.wrCount)   countQ <= regWdata[CNT_W-1:0];
      else if (strb.tick) countQ <= countQ + 1'b1;
      if (strb.wrTrim) begin
        divQ  <= regWdata[DIV_W-1:0];
        trimQ <= regWdata[TRIM_LSB +: TRIM_W];
      end
    end
  end

  // Status: enables and sticky flags, set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickEn    <= 1'b0;
      alarmEn   <= 1'b0;
      tickFlag  <= 1'b0;
      alarmFlag <= 1'b0;
      matchQ    <= 1'b1;
    end else begin
      matchQ <= matchNow;
      if (strb.wrStatus) begin
        tickEn  <= regWdata[ST_TICK_EN];
        alarmEn <= regWdata[ST_ALARM_EN];
      end
      tickFlag  <= strb.tick || (tickFlag && !clrTick);
      alarmFlag <= matchRise || (alarmFlag && !clrAlarm);
    end
  end

  always_comb begin
    statusQ                = '0;
    statusQ[ST_TICK_EN]    = tickEn;
    statusQ[ST_ALARM_EN]   = alarmEn;
    statusQ[ST_TICK_FLAG]  = tickFlag;
    statusQ[ST_ALARM_FLAG] = alarmFlag;
  end

  assign tickIrq  = tickFlag && tickEn;
  assign alarmIrq = alarmFlag && alarmEn;

  // Combinational read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_ALARM:  regRdata[CNT_W-1:0] = alarmQ;
      OFS_COUNT:  regRdata[CNT_W-1:0] = countQ;
      OFS_TRIM: begin
        regRdata[DIV_W-1:0]           = divQ;
        regRdata[TRIM_LSB +: TRIM_W]  = trimQ;
      end
      OFS_STATUS: regRdata[3:0]       = statusQ;
      default:    regRdata            = '0;
    endcase
  end

endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int DIV_W          = 16,
  parameter int TRIM_W         = 10,
  parameter int TRIM_SPAN_LOG2 = 10,
  parameter int DEFAULT_DIV    = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oscTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              tickIrq,
  output logic              alarmIrq
);

  rtcStrobes_t       strb;
  logic [CNT_W-1:0]  alarmQ;
  logic [CNT_W-1:0]  countQ;
  logic [DIV_W-1:0]  divQ;
  logic [TRIM_W-1:0] trimQ;
  logic [3:0]        statusQ;

  secs_rtc_ctrl #(
    .DIV_W         (DIV_W),
    .TRIM_W        (TRIM_W),
    .TRIM_SPAN_LOG2(TRIM_SPAN_LOG2),
    .DEFAULT_DIV   (DEFAULT_DIV)
  ) ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .oscTick(oscTick),
    .regWr  (regWr),
    .regAddr(regAddr),
    .divVal (divQ),
    .trimVal(trimQ),
    .strb   (strb)
  );

  secs_rtc_dp #(
    .CNT_W (CNT_W),
    .DIV_W (DIV_W),
    .TRIM_W(TRIM_W)
  ) dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .alarmQ  (alarmQ),
    .countQ  (countQ),
    .divQ    (divQ),
    .trimQ   (trimQ),
    .statusQ (statusQ),
    .tickIrq (tickIrq),
    .alarmIrq(alarmIrq)
  );

endmodule

// File: rtl/secs_rtc_checker.sv
module secs_rtc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrCount,
  input logic             wrStatus,
  input logic             wrTrim,
  input logic             clrTickBit,
  input logic [CNT_W-1:0] countQ,
  input logic [CNT_W-1:0] alarmQ,
  input logic [3:0]       statusQ,
  input logic             tickIrq,
  input logic             alarmIrq
);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrCount) |=> (countQ == $past(countQ) + CNT_W'(1)));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wrCount) |=> $stable(countQ));

  // R5
  tick_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> statusQ[1]);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStatus && clrTickBit && !tick) |=> !statusQ[1]);

  // R6
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusQ[0]) |-> $past(countQ == alarmQ));

  // R7
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R8
  reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrTrim |=> !tick);

  // R11
  tick_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> (statusQ[3] && statusQ[1]));

  // R11
  alarm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarmIrq |-> (statusQ[2] && statusQ[0]));

endmodule

bind secs_rtc secs_rtc_checker #(.CNT_W(CNT_W)) checker_inst (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (strb.tick),
  .wrCount   (strb.wrCount),
  .wrStatus  (strb.wrStatus),
  .wrTrim    (strb.wrTrim),
  .clrTickBit(regWdata[1]),
  .countQ    (countQ),
  .alarmQ    (alarmQ),
  .statusQ   (statusQ),
  .tickIrq   (tickIrq),
  .alarmIrq  (alarmIrq)
);

// File: tb/secs_rtc_test.sv
module secs_rtc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oscTick = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        tickIrq, alarmIrq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_ALM = 5'h00, A_CNT = 5'h04, A_TRM = 5'h08, A_STS = 5'h10;

  // {isWrite, addr, data, expected read}
  localparam int NVEC = 13;
  localparam logic [69:0] VECS [NVEC] = '{
    {1'b1, 5'h00, 32'hDEADBEEF, 32'h0},
    {1'b0, 5'h00, 32'h0,        32'hDEADBEEF},
    {1'b1, 5'h04, 32'h12345678, 32'h0},
    {1'b0, 5'h04, 32'h0,        32'h12345678},
    {1'b1, 5'h08, 32'hFFFFFFFF, 32'h0},
    {1'b0, 5'h08, 32'h0,        32'h03FFFFFF},
    {1'b1, 5'h0C, 32'hFFFFFFFF, 32'h0},
    {1'b0, 5'h0C, 32'h0,        32'h0},
    {1'b1, 5'h10, 32'hFFFFFFFF, 32'h0},
    {1'b0, 5'h10, 32'h0,        32'h0000000C},
    {1'b1, 5'h10, 32'h00000003, 32'h0},
    {1'b0, 5'h10, 32'h0,        32'h0},
    {1'b0, 5'h14, 32'h0,        32'h0}
  };

  secs_rtc uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .oscTick (oscTick),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .tickIrq (tickIrq),
    .alarmIrq(alarmIrq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic osc(input int n);
    oscTick = 1'b1;
    repeat (n) @(negedge clk);
    oscTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rdChk(A_ALM, 32'h0, "R1 alarm");
    rdChk(A_CNT, 32'h0, "R1 count");
    rdChk(A_TRM, 32'h0, "R1 trim");
    rdChk(A_STS, 32'h0, "R1 status");
    chk("R1 irqs", {30'h0, tickIrq, alarmIrq}, 32'h0);

    // R2 R3 R8: register vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][69]) wr(VECS[i][68:64], VECS[i][63:32]);
      else rdChk(VECS[i][68:64], VECS[i][31:0], $sformatf("R2/R3/R8 vector %0d", i));
    end

    // R7: divider 3 gives a tick per 4 enables
    wr(A_TRM, 32'd3);
    wr(A_CNT, 32'd0);
    wr(A_STS, 32'h3);
    osc(7);
    rdChk(A_CNT, 32'd1, "R7 seven enables");
    osc(1);
    rdChk(A_CNT, 32'd2, "R7 eight enables");
    for (int i = 0; i < 8; i++) begin
      oscTick = 1'b1; @(negedge clk);
      oscTick = 1'b0; @(negedge clk);
    end
    rdChk(A_CNT, 32'd4, "R7 gated enables");

    // R5 R11 R3: tick flag and interrupt
    rdChk(A_STS, 32'h2, "R5 tick flag set");
    chk("R11 tickIrq masked", {31'h0, tickIrq}, 32'h0);
    wr(A_STS, 32'h8);
    rdChk(A_STS, 32'hA, "R3 enable write keeps flag");
    chk("R11 tickIrq enabled", {31'h0, tickIrq}, 32'h1);
    chk("R11 alarmIrq independent", {31'h0, alarmIrq}, 32'h0);
    wr(A_STS, 32'hA);
    rdChk(A_STS, 32'h8, "R3 write one clears flag");
    chk("R11 tickIrq after clear", {31'h0, tickIrq}, 32'h0);
    osc(4);
    wr(A_STS, 32'h8);
    rdChk(A_STS, 32'hA, "R3 write zero keeps flag");
    wr(A_STS, 32'h2);
    rdChk(A_STS, 32'h0, "R3 clear all");

    // R6: alarm reached by tick
    wr(A_ALM, 32'd7);
    osc(8);
    rdChk(A_CNT, 32'd7, "R6 count at alarm");
    rdChk(A_STS, 32'h2, "R6 alarm flag one cycle late");
    @(negedge clk);
    rdChk(A_STS, 32'h3, "R6 alarm flag set");
    chk("R11 alarmIrq masked", {31'h0, alarmIrq}, 32'h0);
    wr(A_STS, 32'h4);
    chk("R11 alarmIrq enabled", {31'h0, alarmIrq}, 32'h1);
    wr(A_STS, 32'h5);
    repeat (3) @(negedge clk);
    rdChk(A_STS, 32'h6, "R6 no re-set while equal");
    chk("R11 alarmIrq cleared", {31'h0, alarmIrq}, 32'h0);
    // R6: alarm reached by counter write
    wr(A_CNT, 32'd9);
    wr(A_CNT, 32'd7);
    @(negedge clk);
    rdChk(A_STS, 32'h7, "R6 alarm via write");
    wr(A_STS, 32'h3);

    // R5: tick and clear on the same edge, set wins
    wr(A_TRM, 32'd3);
    regAddr = A_CNT; #1; snap = regRdata;
    oscTick = 1'b1;
    repeat (3) @(negedge clk);
    regWr = 1'b1; regAddr = A_STS; regWdata = 32'h2;
    @(negedge clk);
    regWr = 1'b0; oscTick = 1'b0;
    rdChk(A_STS, 32'h2, "R5 set beats clear");
    rdChk(A_CNT, snap + 32'd1, "R4 tick during clear");

    // R4: tick and counter write on the same edge, write wins
    wr(A_TRM, 32'd3);
    oscTick = 1'b1;
    repeat (3) @(negedge clk);
    regWr = 1'b1; regAddr = A_CNT; regWdata = 32'd100;
    @(negedge clk);
    regWr = 1'b0; oscTick = 1'b0;
    rdChk(A_CNT, 32'd100, "R4 write beats tick");

    // R4: wrap
    wr(A_CNT, 32'hFFFFFFFF);
    wr(A_TRM, 32'd3);
    osc(4);
    rdChk(A_CNT, 32'h0, "R4 wrap");

    // R8: reload on trim/divider write
    wr(A_CNT, 32'd50);
    osc(2);
    wr(A_TRM, 32'd3);
    osc(3);
    rdChk(A_CNT, 32'd50, "R8 reload restarts count");
    osc(1);
    rdChk(A_CNT, 32'd51, "R8 tick after reload");

    // R9: zero divider uses 32768 enables
    wr(A_TRM, 32'd0);
    wr(A_CNT, 32'd0);
    osc(32767);
    rdChk(A_CNT, 32'd0, "R9 before default period");
    osc(1);
    rdChk(A_CNT, 32'd1, "R9 default period");

    // R10: trim of 5 on every 1024th period
    wr(A_TRM, 32'h0005_0003);
    wr(A_CNT, 32'd0);
    osc(4092);
    rdChk(A_CNT, 32'd1023, "R10 untrimmed periods");
    osc(8);
    rdChk(A_CNT, 32'd1023, "R10 trimmed period not done");
    osc(1);
    rdChk(A_CNT, 32'd1024, "R10 trimmed period done");
    osc(4);
    rdChk(A_CNT, 32'd1025, "R10 normal period after trim");

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finishRun();
    end
  end

endmodule